// File: doc/BRIEF.md
# Video Test Pattern and Self-Test Controller

This block sits in front of a 10-bit video serializer. It selects the word stream that feeds the serializer: either the parallel input word, or a word from an internal pattern generator. It also produces a go/no-go self-test flag.

Pattern mode is requested by raising an enable input once the PLL reports lock. At that rising edge the block latches a 4-bit pattern code from the low data bits and starts a simplified raster of lines and fields. A running CRC-16 of the words that actually leave the block is compared, field by field, with a CRC of the words the generator meant to send. For the two self-test codes, the pass flag rises after two clean fields. An error holds the flag low until the enable is dropped.

The raster is small and set by parameters. A line has `W43` words (16) or `W169` words (20), and a field has `LN` lines (3) or `LP` lines (4).

Top module: `vtp_ctrl`

## Requirements
- R1: While `rst_n` is low, `dout` is 0 and `pass_out` is 0.
- R2: Outside pattern mode, `dout` equals the `din` value sampled at the previous clock edge.
- R3: A start happens at a clock edge where `tp_en` is 1, was 0 at the previous edge, and `lock` is 1. At that edge the code is captured from `din[3:0]`, with bit 0 as the LSB. Later changes to `din` do not alter the pattern.
- R4: If `din[9:4]` is nonzero at the rising edge of `tp_en`, pattern mode is not entered and `dout` keeps following `din`.
- R5: A rise of `tp_en` while `lock` is 0 is ignored until `tp_en` falls and rises again.
- R6: The word at raster column x (starting at 0 each line) is set by code bits 1:0, and even and odd columns are treated differently.
  - Flat black (00): even words 0x200, odd words 0x040.
  - PLL word pair (01): even words 0x300, odd words 0x198.
  - EQ word pair (10): even words 0x200, odd words 0x110.
  - Colour bars (11): even words 0x200. Odd words take the luma of bar b = floor(x*8/width), from the list 0x2D0, 0x2A0, 0x240, 0x210, 0x170, 0x140, 0x0E0, 0x040 for b = 0..7, with hard edges between bars.
- R7: Code bit 3 selects the line width: 0 gives `W43` words, 1 gives `W169` words. Code bit 2 selects the field height: 0 gives `LN` lines, 1 gives `LP` lines.
- R8: The first pattern word appears on `dout` one edge after the start edge. Word n follows n edges later. In any cycle where `lock` was 0 at the edge, `dout` carries `din` instead, while the raster position keeps advancing.
- R9: For code 0011 or 0101 with no error, `pass_out` rises exactly 2F+1 edges after the start edge, where F is the number of words in a field.
- R10: `pass_out` stays 0 for every other code.
- R11: A field whose output CRC differs from the generated CRC is an error. It drives `pass_out` low at the end of that field and holds it low until `tp_en` drops. A new start then runs a fresh test.
- R12: The edge that samples `tp_en` low ends pattern mode: `dout` returns to `din` and `pass_out` goes to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 10 | Parallel video word; low 4 bits carry the pattern code at start |
| lock | input | 1 | PLL lock indication, high when locked |
| tp_en | input | 1 | Pattern / self-test enable |
| dout | output | 10 | Word stream to the serializer |
| pass_out | output | 1 | Self-test pass flag |

## Verification
The assertions assume three things about the inputs: `tp_en` is held low through reset, `din` carries no unknown values, and every input changes away from the clock edge. They also assume that start detection compares `tp_en` with its value at the previous edge, so they tie a start to `$rose(tp_en)`. The stimulus drives all inputs one time unit after each rising edge. It keeps `tp_en` low during reset and drops `tp_en` for at least one edge between tests, so every test begins from a clean start. Lock loss is applied only as whole-cycle pulses in the middle of a run, and the input word during those pulses differs from every pattern word, so each such pulse changes the field CRC.

// File: rtl/vtp_ctrl.sv
module vtp_ctrl #(
  parameter int W43  = 16,
  parameter int W169 = 20,
  parameter int LN   = 3,
  parameter int LP   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [9:0] din,
  input  logic       lock,
  input  logic       tp_en,
  output logic [9:0] dout,
  output logic       pass_out
);
  localparam int WMAX = (W169 > W43) ? W169 : W43;
  localparam int LMAX = (LP > LN) ? LP : LN;
  localparam int XW   = $clog2(WMAX) + 1;
  localparam int YW   = $clog2(LMAX) + 1;

  logic          en_q, run, vq, lq, err;
  logic [3:0]    code;
  logic [XW-1:0] x;
  logic [YW-1:0] y;
  logic [9:0]    pw, wq;
  logic [15:0]   crc_g, crc_o;
  logic [1:0]    ok;

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [9:0] d);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 9; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  function automatic logic [9:0] luma(input logic [2:0] b);
    case (b)
      3'd0: luma = 10'h2D0;
      3'd1: luma = 10'h2A0;
      3'd2: luma = 10'h240;
      3'd3: luma = 10'h210;
      3'd4: luma = 10'h170;
      3'd5: luma = 10'h140;
      3'd6: luma = 10'h0E0;
      default: luma = 10'h040;
    endcase
  endfunction

  wire [XW-1:0] wl    = code[3] ? XW'(W169) : XW'(W43);
  wire [YW-1:0] ll    = code[2] ? YW'(LP) : YW'(LN);
  wire          eol   = (x == wl - 1'b1);
  wire          eof   = eol && (y == ll - 1'b1);
  wire          start = tp_en && !en_q && lock && (din[9:4] == 6'd0);
  wire [XW+2:0] x8    = {x, 3'b000};
  wire [XW+2:0] q43   = x8 / (XW+3)'(W43);
  wire [XW+2:0] q169  = x8 / (XW+3)'(W169);
  wire [2:0]    bar   = code[3] ? q169[2:0] : q43[2:0];
  wire [15:0]   g_nx  = crc_upd(crc_g, wq);
  wire [15:0]   o_nx  = crc_upd(crc_o, dout);

  always_comb begin
    if (!x[0]) pw = (code[1:0] == 2'b01) ? 10'h300 : 10'h200;
    else begin
      case (code[1:0])
        2'b00:   pw = 10'h040;
        2'b01:   pw = 10'h198;
        2'b10:   pw = 10'h110;
        default: pw = luma(bar);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      run   <= 1'b0;
      code  <= 4'd0;
      x     <= '0;
      y     <= '0;
      dout  <= 10'd0;
      vq    <= 1'b0;
      lq    <= 1'b0;
      wq    <= 10'd0;
      crc_g <= 16'hFFFF;
      crc_o <= 16'hFFFF;
      err   <= 1'b0;
      ok    <= 2'd0;
    end else begin
      en_q <= tp_en;
      if (!tp_en) run <= 1'b0;
      else if (start) begin
        run  <= 1'b1;
        code <= din[3:0];
      end

      if (start || !tp_en) begin
        x <= '0;
        y <= '0;
      end else if (run) begin
        if (eol) begin
          x <= '0;
          y <= eof ? '0 : y + 1'b1;
        end else x <= x + 1'b1;
      end

      dout <= (run && tp_en && lock) ? pw : din;
      vq   <= run && tp_en;
      wq   <= pw;
      lq   <= eof;

      if (!tp_en) begin
        crc_g <= 16'hFFFF;
        crc_o <= 16'hFFFF;
        err   <= 1'b0;
        ok    <= 2'd0;
      end else if (vq) begin
        if (lq) begin
          crc_g <= 16'hFFFF;
          crc_o <= 16'hFFFF;
          if (g_nx != o_nx) err <= 1'b1;
          else if (ok != 2'd2) ok <= ok + 1'b1;
        end else begin
          crc_g <= g_nx;
          crc_o <= o_nx;
        end
      end
    end
  end

  assign pass_out = run && (code == 4'd3 || code == 4'd5) && !err && (ok == 2'd2);
endmodule

// File: rtl/vtp_ctrl_chk.sv
module vtp_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [9:0] din,
  input logic       lock,
  input logic       tp_en,
  input logic [9:0] dout,
  input logic       pass_out,
  input logic       run,
  input logic       err,
  input logic [3:0] code
);
  p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tp_en) || !$past(lock)) |-> dout == $past(din));

  p_bad_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tp_en) && lock && din[9:4] != 6'd0) |=> !run);

  p_no_lock_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tp_en) && !lock) |=> !run);

  p_bist_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pass_out |-> (code == 4'd3 || code == 4'd5));

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (err && tp_en) |=> err);

  p_pass_needs_en_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pass_out |-> $past(tp_en));
endmodule

bind vtp_ctrl vtp_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .din(din), .lock(lock), .tp_en(tp_en),
  .dout(dout), .pass_out(pass_out), .run(run), .err(err), .code(code)
);

// File: tb/tb_vtp_ctrl.sv
module tb_vtp_ctrl;
  localparam int W43 = 16, W169 = 20, LN = 3, LP = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] din = 10'd0;
  logic       lock = 1'b0;
  logic       tp_en = 1'b0;
  logic [9:0] dout;
  logic       pass_out;

  int checks = 0;
  int errors = 0;
  int n = 0;
  int cur = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vtp_ctrl #(.W43(W43), .W169(W169), .LN(LN), .LP(LP)) dut (
    .clk(clk), .rst_n(rst_n), .din(din), .lock(lock), .tp_en(tp_en),
    .dout(dout), .pass_out(pass_out)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit good, input string req, input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int fld(input int c);
    return (((c & 8) != 0) ? W169 : W43) * (((c & 4) != 0) ? LP : LN);
  endfunction

  function automatic int pat(input int c, input int k);
    int w, xx;
    int lum[8] = '{'h2D0, 'h2A0, 'h240, 'h210, 'h170, 'h140, 'h0E0, 'h040};
    w  = ((c & 8) != 0) ? W169 : W43;
    xx = k % w;
    if (xx % 2 == 0) return ((c & 3) == 1) ? 'h300 : 'h200;
    case (c & 3)
      0: return 'h040;
      1: return 'h198;
      2: return 'h110;
      default: return lum[(xx * 8) / w];
    endcase
  endfunction

  task automatic start(input int c);
    din = 10'(c);
    lock = 1'b1;
    tp_en = 1'b1;
    step();
    cur = c;
    n = 0;
  endtask

  task automatic tick(input bit lk);
    int e;
    lock = lk;
    din = lk ? {6'h2A, ~4'(cur)} : 10'h3FF;
    step();
    e = lk ? pat(cur, n) : 'h3FF;
    if (lk) chk(dout == 10'(e), "R6 R7 R3 pattern word", dout, e);
    else chk(dout == 10'(e), "R8 lock loss passthrough", dout, e);
    n++;
  endtask

  task automatic stop();
    tp_en = 1'b0;
    lock = 1'b1;
    din = 10'h155;
    step();
    chk(dout == 10'h155, "R12 exit passthrough", dout, 'h155);
    chk(pass_out == 1'b0, "R12 pass cleared", pass_out, 0);
    step();
  endtask

  initial begin
    repeat (3) step();
    chk(dout == 10'd0, "R1 reset dout", dout, 0);
    chk(pass_out == 1'b0, "R1 reset pass", pass_out, 0);
    rst_n = 1'b1;

    for (int v = 0; v < 8; v++) begin
      din = 10'(v * 131 + 7);
      step();
      chk(dout == 10'(v * 131 + 7), "R2 passthrough", dout, v * 131 + 7);
    end

    for (int c = 0; c < 16; c++) begin
      bit bist;
      bist = (c == 3) || (c == 5);
      start(c);
      for (int k = 0; k <= 2 * fld(c); k++) begin
        tick(1'b1);
        if (k == 2 * fld(c) - 1) chk(pass_out == 1'b0, "R9 pass not early", pass_out, 0);
        if (k == 2 * fld(c)) begin
          if (bist) chk(pass_out == 1'b1, "R9 pass after two fields", pass_out, 1);
          else chk(pass_out == 1'b0, "R10 no pass for non-test code", pass_out, 0);
        end
      end
      stop();
    end

    din = 10'h013;
    lock = 1'b1;
    tp_en = 1'b1;
    step();
    for (int v = 0; v < 5; v++) begin
      din = 10'(v + 'h2C1);
      step();
      chk(dout == 10'(v + 'h2C1), "R4 invalid code passthrough", dout, v + 'h2C1);
    end
    stop();

    din = 10'h003;
    lock = 1'b0;
    tp_en = 1'b1;
    step();
    lock = 1'b1;
    for (int v = 0; v < 5; v++) begin
      din = 10'(v + 'h0A3);
      step();
      chk(dout == 10'(v + 'h0A3), "R5 rise without lock ignored", dout, v + 'h0A3);
    end
    chk(pass_out == 1'b0, "R5 no pass", pass_out, 0);
    stop();

    start(3);
    for (int k = 0; k <= 3 * fld(3); k++) begin
      tick(!(k >= 10 && k <= 12));
      if (k == 3 * fld(3)) chk(pass_out == 1'b0, "R11 error holds pass low", pass_out, 0);
    end
    stop();
    start(3);
    for (int k = 0; k <= 2 * fld(3); k++) tick(1'b1);
    chk(pass_out == 1'b1, "R11 fresh test passes", pass_out, 1);
    stop();

    start(5);
    for (int k = 0; k <= 3 * fld(5); k++) begin
      tick(k != 2 * fld(5) + 1);
      if (k == 3 * fld(5) - 1) chk(pass_out == 1'b1, "R11 pass held until field end", pass_out, 1);
      if (k == 3 * fld(5)) chk(pass_out == 1'b0, "R11 pass drops on error", pass_out, 0);
    end
    stop();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule